// File: doc/BRIEF.md
# Weighted Ratio Record Distributor

This block sits in front of two groups of streaming sorting cells. It takes one stream of fixed-length records, each `REC_WORDS` 16-bit words long (50 by default), and sends every record whole to one of two output streams. The split follows a ratio that is loaded before traffic starts, with one weight per output. A port with twice as many sorting cells behind it therefore receives twice as many records. Each ratio period serves output A for its full weight and then output B for its full weight, and then starts again.

Every transfer is a 16-bit word with a one-bit tag under valid/ready flow control. A word with the tag set that arrives at a record boundary is an end-of-block command, for example a reset or flush marker. The block copies that command to both outputs, so the sorting cells on each side learn that the block is complete and can begin merging. The input stays closed until both copies have been taken. Record words are passed straight through without a register stage. Input ready follows the ready of the output that was selected.

The control is a three-state machine:
- `ST_BOUND`: waiting at a record boundary.
  - `T_START`: a data word is accepted and the record has more than one word, so the machine moves to `ST_BODY`.
  - `T_CMD`: a command word is accepted, so the machine moves to `ST_FLUSH`.
  - `T_SINGLE`: a one-word record is accepted, so the machine stays in `ST_BOUND`.
- `ST_BODY`: inside a record.
  - `T_END`: the last word is accepted, so the machine returns to `ST_BOUND`.
- `ST_FLUSH`: the two command copies are pending.
  - `T_DONE`: the last pending copy is taken, so the machine returns to `ST_BOUND`.

Top module: `rs_distributor`

## Requirements
- R1: After reset, neither output is valid, and the first record goes to the first slot of a ratio period.
- R2: The output port is chosen only at a record boundary. All `REC_WORDS` words of a record leave on that one port, in order and unchanged, with tag 0.
- R3: With effective weights WA and WB, a ratio period holds WA+WB records. The first WA records go to output A and the next WB records go to output B, and then the period repeats. With WA=4 and WB=1, exactly 4 of every 5 records go to A.
- R4: If one weight is 0, every record goes to the other port. If both weights are 0, the block splits 1:1.
- R5: The tag bit is bit `in_tag`, where 1 means command. It is treated as a command only on the first word at a record boundary. Inside a record the tag is ignored: the word is forwarded as data with tag 0 and counts toward the record length.
- R6: A command word appears on both outputs with tag 1 and its 16-bit data unchanged. Each copy completes its own handshake independently.
- R7: While either command copy is still pending, `in_ready` is low.
- R8: A command restarts the ratio period, so the next record goes to the first slot of a new period.
- R9: While a record word is offered and no command is pending, only the selected port is valid, and `in_ready` equals that port's ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wt_a | input | WW | Weight of output A, held static during operation |
| cfg_wt_b | input | WW | Weight of output B, held static during operation |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with valid |
| in_data | input | DW | Input word |
| in_tag | input | 1 | Command tag of the input word |
| a_valid | output | 1 | Output A word valid |
| a_ready | input | 1 | Output A ready |
| a_data | output | DW | Output A word |
| a_tag | output | 1 | Output A command tag |
| b_valid | output | 1 | Output B word valid |
| b_ready | input | 1 | Output B ready |
| b_data | output | DW | Output B word |
| b_tag | output | 1 | Output B command tag |

## Verification
The ratio logic is driven with weights 4:1, 1:1, 2:3, 0:3, 3:0 and 0:0. These separate the ordered A-then-B period from plain alternation, and they show that the zero-weight fallbacks differ from each other. Each setting runs under one of three ready patterns: always ready, random stalls on both ports, and a port A that is ready only rarely. The stalled patterns show that `in_ready` tracks only the selected port, and that a command copy waiting on one side holds back the input. Every run places a command in the middle of the stream. This shows the restart of the ratio period. Each run also includes a record whose eighth word carries a stray tag bit, which tells a command taken at a boundary apart from a tag that must be ignored inside a record.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ST_BOUND = 2'd0,
        ST_BODY  = 2'd1,
        ST_FLUSH = 2'd2
    } rs_state_e;

endpackage

// File: rtl/rs_ratio_sel.sv
module rs_ratio_sel #(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] wt_a,
    input  logic [WW-1:0] wt_b,
    input  logic          rec_done,
    input  logic          restart,
    output logic          sel_b
);
    localparam int SW = WW + 1;

    logic [WW-1:0] eff_a;
    logic [WW-1:0] eff_b;
    logic [SW-1:0] period;
    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_inc;

    always_comb begin
        if (wt_a == '0 && wt_b == '0) begin
            eff_a = WW'(1);
            eff_b = WW'(1);
        end else begin
            eff_a = wt_a;
            eff_b = wt_b;
        end
        period   = {1'b0, eff_a} + {1'b0, eff_b};
        slot_inc = slot_q + SW'(1);
        sel_b    = (slot_q >= {1'b0, eff_a});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            slot_q <= '0;
        end else if (rec_done) begin
            if (slot_inc >= period) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_inc;
            end
        end
    end

endmodule

// File: rtl/rs_word_pos.sv
module rs_word_pos #(
    parameter int REC_WORDS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_fire,
    output logic last_word
);
    localparam int CW = (REC_WORDS > 1) ? $clog2(REC_WORDS) : 1;

    logic [CW-1:0] pos_q;

    assign last_word = (pos_q == CW'(REC_WORDS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (word_fire) begin
            if (last_word) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/rs_cmd_dup.sv
module rs_cmd_dup #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          a_ready,
    input  logic          b_ready,
    output logic          pend_a,
    output logic          pend_b,
    output logic [DW-1:0] hold_data,
    output logic          done
);
    logic take_a;
    logic take_b;

    assign take_a = pend_a & a_ready;
    assign take_b = pend_b & b_ready;
    assign done   = (pend_a | pend_b) & (~pend_a | a_ready) & (~pend_b | b_ready);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_a    <= 1'b0;
            pend_b    <= 1'b0;
            hold_data <= '0;
        end else if (load) begin
            pend_a    <= 1'b1;
            pend_b    <= 1'b1;
            hold_data <= load_data;
        end else begin
            if (take_a) pend_a <= 1'b0;
            if (take_b) pend_b <= 1'b0;
        end
    end

endmodule

// File: rtl/rs_distributor.sv
module rs_distributor
    import rs_pkg::*;
#(
    parameter int DW        = 16,
    parameter int WW        = 4,
    parameter int REC_WORDS = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] cfg_wt_a,
    input  logic [WW-1:0] cfg_wt_b,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_tag,
    output logic          a_valid,
    input  logic          a_ready,
    output logic [DW-1:0] a_data,
    output logic          a_tag,
    output logic          b_valid,
    input  logic          b_ready,
    output logic [DW-1:0] b_data,
    output logic          b_tag
);
    rs_state_e     st_q;
    rs_state_e     st_d;
    logic          sel_b;
    logic          last_word;
    logic          is_cmd;
    logic          in_fire;
    logic          data_fire;
    logic          cmd_fire;
    logic          rec_done;
    logic          pend_a;
    logic          pend_b;
    logic          cmd_done;
    logic [DW-1:0] hold_data;
    logic          sel_ready;

    // command only on the first word at a record boundary
    assign is_cmd    = (st_q == ST_BOUND) & in_tag;
    assign sel_ready = sel_b ? b_ready : a_ready;
    assign in_fire   = in_valid & in_ready;
    assign cmd_fire  = in_fire & is_cmd;
    assign data_fire = in_fire & ~is_cmd;
    assign rec_done  = data_fire & last_word;

    rs_ratio_sel #(.WW(WW)) u_ratio (
        .clk      (clk),
        .rst_n    (rst_n),
        .wt_a     (cfg_wt_a),
        .wt_b     (cfg_wt_b),
        .rec_done (rec_done),
        .restart  (cmd_fire),
        .sel_b    (sel_b)
    );

    rs_word_pos #(.REC_WORDS(REC_WORDS)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_fire (data_fire),
        .last_word (last_word)
    );

    rs_cmd_dup #(.DW(DW)) u_dup (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cmd_fire),
        .load_data (in_data),
        .a_ready   (a_ready),
        .b_ready   (b_ready),
        .pend_a    (pend_a),
        .pend_b    (pend_b),
        .hold_data (hold_data),
        .done      (cmd_done)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_BOUND;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_BOUND: begin
                if (cmd_fire) begin
                    st_d = ST_FLUSH;          // T_CMD
                end else if (data_fire && !last_word) begin
                    st_d = ST_BODY;           // T_START
                end                           // T_SINGLE keeps ST_BOUND
            end
            ST_BODY: begin
                if (rec_done) st_d = ST_BOUND; // T_END
            end
            ST_FLUSH: begin
                if (cmd_done) st_d = ST_BOUND; // T_DONE
            end
            default: st_d = ST_BOUND;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        a_valid  = 1'b0;
        b_valid  = 1'b0;
        a_data   = in_data;
        b_data   = in_data;
        a_tag    = 1'b0;
        b_tag    = 1'b0;
        unique case (st_q)
            ST_BOUND: begin
                if (in_tag) begin
                    in_ready = 1'b1;
                end else begin
                    in_ready = sel_ready;
                    a_valid  = in_valid & ~sel_b;
                    b_valid  = in_valid & sel_b;
                end
            end
            ST_BODY: begin
                in_ready = sel_ready;
                a_valid  = in_valid & ~sel_b;
                b_valid  = in_valid & sel_b;
            end
            ST_FLUSH: begin
                a_valid = pend_a;
                b_valid = pend_b;
                a_data  = hold_data;
                b_data  = hold_data;
                a_tag   = 1'b1;
                b_tag   = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rs_dist_chk.sv
module rs_dist_chk
    import rs_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      in_valid,
    input logic      in_ready,
    input logic      in_tag,
    input logic      a_valid,
    input logic      a_ready,
    input logic      a_tag,
    input logic      b_valid,
    input logic      b_ready,
    input logic      b_tag,
    input rs_state_e st,
    input logic      sel_b
);
    // R6
    cmd_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_tag && st == ST_BOUND)
        |=> (a_valid && b_valid && a_tag && b_tag));

    // R7
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_valid && a_tag) || (b_valid && b_tag)) |-> !in_ready);

    // R2
    rec_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BODY && $past(st) == ST_BODY) |-> $stable(sel_b));

    // R9
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && b_valid) |-> (a_tag && b_tag));

    // R9
    conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && st != ST_FLUSH && !(st == ST_BOUND && in_tag))
        |-> ((a_valid && a_ready) ^ (b_valid && b_ready)));

endmodule

bind rs_distributor rs_dist_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_tag   (in_tag),
    .a_valid  (a_valid),
    .a_ready  (a_ready),
    .a_tag    (a_tag),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .b_tag    (b_tag),
    .st       (st_q),
    .sel_b    (sel_b)
);

// File: tb/sim_rs_distributor.sv
module sim_rs_distributor;
    localparam int RW = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_wt_a = '0;
    logic [3:0]  cfg_wt_b = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_tag = 1'b0;
    logic        a_valid, a_ready = 1'b0, a_tag;
    logic        b_valid, b_ready = 1'b0, b_tag;
    logic [15:0] a_data, b_data;

    always #4 clk = ~clk;

    rs_distributor #(.DW(16), .WW(4), .REC_WORDS(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wt_a(cfg_wt_a), .cfg_wt_b(cfg_wt_b),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_tag(in_tag),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_tag(a_tag),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_tag(b_tag)
    );

    int checks = 0;
    int fails  = 0;
    int mode   = 0;
    int wa_e = 1, wb_e = 1, slot = 0, wpos = 0;
    bit pa = 0, pb = 0;
    logic [16:0] q_a[$];
    logic [16:0] q_b[$];
    logic [15:0] wctr = 16'h1000;

    task automatic report(string req, string what, int act, int exp);
        fails++;
        $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    endtask

    // behavioural reference model, compared every clock
    always @(negedge clk) begin
        if (!rst_n) begin
            slot = 0; wpos = 0; pa = 0; pb = 0;
            q_a.delete(); q_b.delete();
        end else begin
            bit dest_b;
            logic [16:0] e;
            dest_b = (slot >= wa_e);
            // R7: input closed while a command copy is pending
            if (pa || pb) begin
                checks++;
                if (in_ready) report("R7", "in_ready", 1, 0);
            end else if (in_valid && !(wpos == 0 && in_tag)) begin
                // R9: only selected port valid, ready follows it
                checks++;
                if (dest_b) begin
                    if ({b_valid, a_valid, in_ready} != {1'b1, 1'b0, b_ready})
                        report("R9", "{bv,av,ir}", {b_valid, a_valid, in_ready}, {1'b1, 1'b0, b_ready});
                end else begin
                    if ({a_valid, b_valid, in_ready} != {1'b1, 1'b0, a_ready})
                        report("R9", "{av,bv,ir}", {a_valid, b_valid, in_ready}, {1'b1, 1'b0, a_ready});
                end
            end
            if (in_valid && in_ready) begin
                if (wpos == 0 && in_tag) begin
                    // R6 duplicate, R8 restart period
                    q_a.push_back({1'b1, in_data});
                    q_b.push_back({1'b1, in_data});
                    pa = 1; pb = 1; slot = 0;
                end else begin
                    // R2/R3/R4/R5: data (tag forced 0) to the slot's port
                    if (dest_b) q_b.push_back({1'b0, in_data});
                    else        q_a.push_back({1'b0, in_data});
                    wpos++;
                    if (wpos == RW) begin
                        wpos = 0;
                        slot++;
                        if (slot >= wa_e + wb_e) slot = 0;
                    end
                end
            end
            if (a_valid && a_ready) begin
                checks++;
                if (q_a.size() == 0) report("R3", "unexpected word on A", {a_tag, a_data}, 0);
                else begin
                    e = q_a.pop_front();
                    if ({a_tag, a_data} != e) report("R2/R3 port A", "word", {a_tag, a_data}, e);
                end
                if (a_tag) pa = 0;
            end
            if (b_valid && b_ready) begin
                checks++;
                if (q_b.size() == 0) report("R3", "unexpected word on B", {b_tag, b_data}, 0);
                else begin
                    e = q_b.pop_front();
                    if ({b_tag, b_data} != e) report("R2/R3 port B", "word", {b_tag, b_data}, e);
                end
                if (b_tag) pb = 0;
            end
        end
    end

    // ready patterns
    initial begin
        forever begin
            @(posedge clk); #1;
            case (mode)
                0: begin a_ready = 1'b1; b_ready = 1'b1; end
                1: begin a_ready = 1'($urandom % 2); b_ready = 1'($urandom % 2); end
                default: begin a_ready = ($urandom % 4 == 0); b_ready = 1'($urandom % 2); end
            endcase
        end
    end

    task automatic send_word(input logic [15:0] d, input logic t);
        in_valid = 1'b1;
        in_data  = d;
        in_tag   = t;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_tag   = 1'b0;
        if (mode != 0 && $urandom % 8 == 0) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic send_rec(input int tagpos);
        for (int w = 0; w < RW; w++) begin
            send_word(wctr, (tagpos > 0) && (w == tagpos));
            wctr = wctr + 16'd1;
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (q_a.size() == 0 && q_b.size() == 0 && !pa && !pb) break;
        end
        checks++;
        if (q_a.size() + q_b.size() != 0) report("R3", "words left undelivered", q_a.size() + q_b.size(), 0);
        @(posedge clk); #1;
    endtask

    task automatic run(input int wa, input int wb, input int m, input int nrec);
        mode = m;
        rst_n = 1'b0;
        cfg_wt_a = 4'(wa);
        cfg_wt_b = 4'(wb);
        if (wa == 0 && wb == 0) begin wa_e = 1; wb_e = 1; end // R4
        else begin wa_e = wa; wb_e = wb; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: no output valid after reset
        checks++;
        if (a_valid || b_valid) report("R1", "valid after reset", {a_valid, b_valid}, 0);
        @(posedge clk); #1;
        for (int r = 0; r < nrec / 2; r++) send_rec(0);
        send_word(16'hC0DE, 1'b1);                 // R6, R8
        send_rec(7);                               // R5 stray tag mid-record
        for (int r = 1; r < nrec - nrec / 2; r++) send_rec(0);
        send_word(16'hF1A5, 1'b1);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        report("ALL", "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        run(4, 1, 1, 10);   // R3 four of five to A
        run(1, 1, 0, 6);
        run(0, 3, 1, 5);    // R4 all to B
        run(0, 0, 2, 6);    // R4 both zero -> 1:1
        run(2, 3, 1, 12);
        run(3, 0, 0, 4);    // R4 all to A
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule